// File: doc/BRIEF.md
# Cache Cluster Performance Counter Bank

This block holds the hardware counters that measure activity in a cache cluster. There is a bank of `NUM_EVT` event counters, each 32 bits wide, plus one free-running cycle counter that is 64 bits wide. Each event counter advances on a one-cycle increment pulse. The pulses come from an event selector outside this block. The cycle counter advances once on every clock. Counting is gated twice. A global enable bit must be set, and so must the counter's own bit in a count-enable mask.

Software reaches every register through one indirect port. The port has a write strobe, an address, a 64-bit write word and a combinational read word. The count-enable, interrupt-enable and overflow-status masks each have a set address and a clear address, so a single bit changes without a read-modify-write. When a counter wraps, its status bit becomes set. A single level interrupt is raised while any status bit whose interrupt-enable bit is also set is active. Software handles an overflow in two steps: it reads the status, then writes the value it read to the clear address. An overflow that lands in the same cycle as that clear is kept.

Top module: `pmu_counter_bank`

## Requirements
- R1: A read of the global control register (address 0x00) returns the enable flag in bit 0 and `NUM_EVT` in bits 15:11. All other bits read 0.
- R2: Counting requires global enable = 1 and the counter's count-enable bit = 1. Event counter i then adds one for each cycle its pulse input is high. The cycle counter adds one every cycle. While global enable is 0, no counter changes except through a bus write.
- R3: A write to the global control register sets the enable flag from bit 0. Bit 1 = 1 zeroes every event counter and bit 2 = 1 zeroes the cycle counter, so the value 0x6 zeroes all counters and leaves counting disabled.
- R4: Each mask has two addresses. Count-enable is at 0x01 (set) and 0x02 (clear), interrupt-enable at 0x03/0x04, and overflow status at 0x05/0x06. Writing a 1 sets or clears only that bit. A read of either address returns the current mask. Unimplemented bits read 0.
- R5: In every mask, event counter i uses bit i for i = 0..NUM_EVT-1, and the cycle counter always uses bit 31.
- R6: An event counter wraps from 0xFFFFFFFF to 0 and the cycle counter wraps from all ones (64 bits) to 0. The counter's status bit becomes 1 on the same clock edge that the value becomes 0.
- R7: If a counter overflows in the same cycle that its status bit is written to the clear address, the bit stays 1.
- R8: `irq` is high exactly while some bit is 1 in both the overflow status and the interrupt-enable mask.
- R9: Event counter i has four registers at 0x20 + 0x10*i: control (+0), value (+1), filter (+2) and type (+3). The cycle counter has its control register at 0x08 and its value at 0x09. Control, filter and type are 32-bit storage that read back what was written.
- R10: A counter's value register may be written at any time. A write wins over an increment in the same cycle.
- R11: A read of any address not listed above returns 0. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_EVT | One increment pulse per event counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level overflow interrupt |

## Verification
The counting path is driven in several ways:

- **Random pulse trains with random count-enable masks.** The per-counter totals show whether counters are wrongly coupled to each other and whether the mask gates each counter correctly.
- **A burst of pulses while global enable is low.** This separates the global gate from the per-counter gate.
- **A value write while the pulse is held high.** This shows whether load priority is correct and whether counting resumes cleanly afterwards.
- **Values preloaded just below the wrap point.** Preloads on an event counter and on the cycle counter check that the status bit lands on bit i or on bit 31 respectively.
- **A status clear that lands on the overflow cycle.** This shows whether an overflow can be lost.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int CYC_BIT       = 31;
    localparam int NUM_FIELD_LSB = 11;
    localparam int EVT_W         = 32;
    localparam int CYC_W         = 64;
    localparam int BUS_W         = 64;
    localparam int CNT_BASE      = 'h20;
    localparam int CNT_STRIDE    = 'h10;

    typedef enum logic [1:0] {
        MK_CEN,
        MK_IEN,
        MK_OVF
    } mask_kind_e;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_GCTRL,
        RG_MSET,
        RG_MCLR,
        RG_CYC_CTRL,
        RG_CYC_VAL,
        RG_EV_CTRL,
        RG_EV_VAL,
        RG_EV_FILT,
        RG_EV_TYPE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        mask_kind_e mask;
        logic [4:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [15:0] addr, input int num_evt);
        dec_t d;
        logic [15:0] off;
        d.kind = RG_NONE;
        d.mask = MK_CEN;
        d.idx  = '0;
        off    = addr - 16'(CNT_BASE);
        case (addr)
            16'h00: d.kind = RG_GCTRL;
            16'h01: begin d.kind = RG_MSET; d.mask = MK_CEN; end
            16'h02: begin d.kind = RG_MCLR; d.mask = MK_CEN; end
            16'h03: begin d.kind = RG_MSET; d.mask = MK_IEN; end
            16'h04: begin d.kind = RG_MCLR; d.mask = MK_IEN; end
            16'h05: begin d.kind = RG_MSET; d.mask = MK_OVF; end
            16'h06: begin d.kind = RG_MCLR; d.mask = MK_OVF; end
            16'h08: d.kind = RG_CYC_CTRL;
            16'h09: d.kind = RG_CYC_VAL;
            default: begin
                if (int'(addr) >= CNT_BASE && int'(addr) < CNT_BASE + num_evt * CNT_STRIDE) begin
                    d.idx = off[8:4];
                    case (off[3:0])
                        4'h0:    d.kind = RG_EV_CTRL;
                        4'h1:    d.kind = RG_EV_VAL;
                        4'h2:    d.kind = RG_EV_FILT;
                        4'h3:    d.kind = RG_EV_TYPE;
                        default: d.kind = RG_NONE;
                    endcase
                end
            end
        endcase
        return d;
    endfunction

    function automatic logic [31:0] impl_mask(input int num_evt);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < num_evt; i++) m[i] = 1'b1;
        m[CYC_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);

    assign wrap = inc & ~ld & ~clr & (&value);

    always_ff @(posedge clk) begin
        if (rst || clr)  value <= '0;
        else if (ld)     value <= ld_val;
        else if (inc)    value <= value + W'(1);
    end

    // R10
    ld_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> value == $past(ld_val));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> value == '0);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld && !clr && !inc) |=> $stable(value));

endmodule

// File: rtl/pmu_setclr_mask.sv
module pmu_setclr_mask #(
    parameter int          W    = 32,
    parameter logic [31:0] IMPL = 32'hFFFF_FFFF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_w,
    input  logic [W-1:0] clr_w,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] KEEP = IMPL[W-1:0];

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= ((q & ~clr_w) | set_w | hw_set) & KEEP;
    end

    // R7
    hw_keep_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(hw_set & KEEP)) == $past(hw_set & KEEP)));

    // R4
    clr_bit_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(clr_w & ~hw_set & ~set_w)) == '0));

    // R4
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & ~KEEP) == '0));

endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [63:0]        bus_wdata,
    output logic [63:0]        bus_rdata,
    output logic               irq
);

    localparam logic [31:0] IMPL = impl_mask(NUM_EVT);

    dec_t dec;
    assign dec = decode(16'(bus_addr), NUM_EVT);

    // global control
    logic en_q;
    logic wr_g;
    logic clr_evt, clr_cyc;

    assign wr_g    = bus_wr && (dec.kind == RG_GCTRL);
    assign clr_evt = wr_g & bus_wdata[1];
    assign clr_cyc = wr_g & bus_wdata[2];

    always_ff @(posedge clk) begin
        if (rst)       en_q <= 1'b0;
        else if (wr_g) en_q <= bus_wdata[0];
    end

    // set/clear masks
    logic [31:0] cen_q, ien_q, ovf_q, ovf_hw;
    logic [31:0] set_cen, clr_cen, set_ien, clr_ien, set_ovf, clr_ovf;

    always_comb begin
        set_cen = '0; clr_cen = '0;
        set_ien = '0; clr_ien = '0;
        set_ovf = '0; clr_ovf = '0;
        if (bus_wr && dec.kind == RG_MSET) begin
            case (dec.mask)
                MK_CEN:  set_cen = bus_wdata[31:0];
                MK_IEN:  set_ien = bus_wdata[31:0];
                default: set_ovf = bus_wdata[31:0];
            endcase
        end
        if (bus_wr && dec.kind == RG_MCLR) begin
            case (dec.mask)
                MK_CEN:  clr_cen = bus_wdata[31:0];
                MK_IEN:  clr_ien = bus_wdata[31:0];
                default: clr_ovf = bus_wdata[31:0];
            endcase
        end
    end

    pmu_setclr_mask #(.W(32), .IMPL(IMPL)) u_cen (
        .clk(clk), .rst(rst), .set_w(set_cen), .clr_w(clr_cen),
        .hw_set(32'h0), .q(cen_q));

    pmu_setclr_mask #(.W(32), .IMPL(IMPL)) u_ien (
        .clk(clk), .rst(rst), .set_w(set_ien), .clr_w(clr_ien),
        .hw_set(32'h0), .q(ien_q));

    pmu_setclr_mask #(.W(32), .IMPL(IMPL)) u_ovf (
        .clk(clk), .rst(rst), .set_w(set_ovf), .clr_w(clr_ovf),
        .hw_set(ovf_hw), .q(ovf_q));

    // event counters and their storage registers
    logic [EVT_W-1:0] evt_val  [NUM_EVT];
    logic [31:0]      evt_ctrl [NUM_EVT];
    logic [31:0]      evt_filt [NUM_EVT];
    logic [31:0]      evt_type [NUM_EVT];
    logic [NUM_EVT-1:0] evt_wrap;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        logic sel;
        assign sel = bus_wr && (dec.idx == 5'(i));

        pmu_counter #(.W(EVT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr_evt),
            .ld     (sel && dec.kind == RG_EV_VAL),
            .ld_val (bus_wdata[EVT_W-1:0]),
            .inc    (en_q & cen_q[i] & evt_pulse[i]),
            .value  (evt_val[i]),
            .wrap   (evt_wrap[i])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                evt_ctrl[i] <= '0;
                evt_filt[i] <= '0;
                evt_type[i] <= '0;
            end else if (sel) begin
                if (dec.kind == RG_EV_CTRL) evt_ctrl[i] <= bus_wdata[31:0];
                if (dec.kind == RG_EV_FILT) evt_filt[i] <= bus_wdata[31:0];
                if (dec.kind == RG_EV_TYPE) evt_type[i] <= bus_wdata[31:0];
            end
        end

        // R6
        evt_ovf_chk: assert property (@(posedge clk) disable iff (rst)
            evt_wrap[i] |=> ovf_q[i]);

        // R2
        off_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!en_q && !bus_wr) |=> $stable(evt_val[i]));
    end

    // cycle counter
    logic [CYC_W-1:0] cyc_val;
    logic [31:0]      cyc_ctrl;
    logic             cyc_wrap;

    pmu_counter #(.W(CYC_W)) u_cyc (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_cyc),
        .ld     (bus_wr && dec.kind == RG_CYC_VAL),
        .ld_val (bus_wdata),
        .inc    (en_q & cen_q[CYC_BIT]),
        .value  (cyc_val),
        .wrap   (cyc_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst)                                  cyc_ctrl <= '0;
        else if (bus_wr && dec.kind == RG_CYC_CTRL) cyc_ctrl <= bus_wdata[31:0];
    end

    always_comb begin
        ovf_hw                = '0;
        ovf_hw[NUM_EVT-1:0]   = evt_wrap;
        ovf_hw[CYC_BIT]       = cyc_wrap;
    end

    assign irq = |(ovf_q & ien_q);

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (dec.kind)
            RG_GCTRL: begin
                bus_rdata[0] = en_q;
                bus_rdata[NUM_FIELD_LSB +: 5] = 5'(NUM_EVT);
            end
            RG_MSET, RG_MCLR: begin
                case (dec.mask)
                    MK_CEN:  bus_rdata[31:0] = cen_q;
                    MK_IEN:  bus_rdata[31:0] = ien_q;
                    default: bus_rdata[31:0] = ovf_q;
                endcase
            end
            RG_CYC_CTRL: bus_rdata[31:0] = cyc_ctrl;
            RG_CYC_VAL:  bus_rdata       = cyc_val;
            default: begin
                for (int i = 0; i < NUM_EVT; i++) begin
                    if (dec.idx == 5'(i)) begin
                        case (dec.kind)
                            RG_EV_CTRL: bus_rdata[31:0] = evt_ctrl[i];
                            RG_EV_VAL:  bus_rdata[31:0] = evt_val[i];
                            RG_EV_FILT: bus_rdata[31:0] = evt_filt[i];
                            RG_EV_TYPE: bus_rdata[31:0] = evt_type[i];
                            default:    ;
                        endcase
                    end
                end
            end
        endcase
    end

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(bus_wr) || ($past(ovf_hw) != '0)));

    // R3
    clr_all_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_evt && clr_cyc) |=> (cyc_val == '0 && evt_val[0] == '0 && !en_q) || $past(bus_wdata[0]));

endmodule

// File: tb/tb_pmu_counter_bank.sv
module tb_pmu_counter_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NUM        = 4;
    localparam int AW         = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NUM-1:0]  evt = '0;
    logic            wr = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [63:0]     wdata = '0;
    logic [63:0]     rdata;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_counter_bank #(.NUM_EVT(NUM), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .evt_pulse(evt), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

    function automatic logic [63:0] exp_impl();
        logic [63:0] m = '0;
        for (int i = 0; i < NUM; i++) m[i] = 1'b1;
        m[31] = 1'b1;
        return m;
    endfunction

    function automatic int ev_addr(input int i, input int sub);
        return 'h20 + i * 'h10 + sub;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [63:0] d);
        @(negedge clk);
        wr = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic expect_reg(input string req, input int a, input logic [63:0] exp);
        addr = AW'(a);
        #1;
        chk(req, rdata, exp);
    endtask

    logic [31:0] model [NUM];
    logic [NUM-1:0] cm;

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg("R1", 'h00, 64'(NUM) << 11);
        expect_reg("R4", 'h01, 64'h0);
        expect_reg("R4", 'h05, 64'h0);
        chk("R8", 64'(irq), 64'h0);

        // R11 unmapped accesses
        wr_reg('h0E, 64'hDEAD_BEEF);
        wr_reg(ev_addr(NUM, 0), 64'h1234);
        expect_reg("R11", 'h0E, 64'h0);
        expect_reg("R11", 'h07, 64'h0);
        expect_reg("R11", ev_addr(NUM, 0), 64'h0);
        expect_reg("R11", ev_addr(0, 5), 64'h0);
        expect_reg("R11", 'h01, 64'h0);
        expect_reg("R11", 'h00, 64'(NUM) << 11);

        // R4 R5 masks
        wr_reg('h01, 64'hFFFF_FFFF);
        expect_reg("R5", 'h01, exp_impl());
        wr_reg('h02, 64'h2);
        expect_reg("R4", 'h02, exp_impl() & ~64'h2);
        expect_reg("R4", 'h01, exp_impl() & ~64'h2);
        wr_reg('h02, 64'hFFFF_FFFF);
        expect_reg("R4", 'h01, 64'h0);

        // R9 storage
        wr_reg(ev_addr(2, 0), 64'hA5A5_0001);
        wr_reg(ev_addr(2, 2), 64'h000E_0007);
        wr_reg(ev_addr(2, 3), 64'h0000_0003);
        wr_reg('h08, 64'h0000_0055);
        expect_reg("R9", ev_addr(2, 0), 64'hA5A5_0001);
        expect_reg("R9", ev_addr(2, 2), 64'h000E_0007);
        expect_reg("R9", ev_addr(2, 3), 64'h0000_0003);
        expect_reg("R9", ev_addr(1, 0), 64'h0);
        expect_reg("R9", 'h08, 64'h55);

        // R2 random pulse trains
        for (int r = 0; r < 3; r++) begin
            wr_reg('h00, 64'h6);
            wr_reg('h02, 64'hFFFF_FFFF);
            cm = (r == 0) ? '1 : NUM'($urandom);
            wr_reg('h01, 64'(cm));
            for (int i = 0; i < NUM; i++) model[i] = '0;
            wr_reg('h00, 64'h1);
            for (int c = 0; c < 150; c++) begin
                evt = NUM'($urandom);
                for (int i = 0; i < NUM; i++) if (evt[i] && cm[i]) model[i]++;
                @(negedge clk);
            end
            evt = '0;
            wr_reg('h00, 64'h0);
            for (int i = 0; i < NUM; i++) expect_reg("R2", ev_addr(i, 1), 64'(model[i]));
        end

        // R2 disabled: pulses have no effect
        wr_reg('h01, 64'hF);
        evt = '1;
        repeat (10) @(negedge clk);
        evt = '0;
        for (int i = 0; i < NUM; i++) expect_reg("R2", ev_addr(i, 1), 64'(model[i]));

        // R3 clear all
        wr_reg('h00, 64'h6);
        for (int i = 0; i < NUM; i++) expect_reg("R3", ev_addr(i, 1), 64'h0);
        expect_reg("R3", 'h09, 64'h0);
        expect_reg("R3", 'h00, 64'(NUM) << 11);

        // R10 write beats increment
        wr_reg('h00, 64'h1);
        @(negedge clk);
        evt[0] = 1'b1;
        wr_reg(ev_addr(0, 1), 64'd100);
        expect_reg("R10", ev_addr(0, 1), 64'd100);
        @(negedge clk);
        expect_reg("R10", ev_addr(0, 1), 64'd101);
        evt = '0;

        // R6 event wrap, R8 interrupt
        wr_reg(ev_addr(1, 1), 64'hFFFF_FFFF);
        @(negedge clk);
        evt[1] = 1'b1;
        @(negedge clk);
        evt = '0;
        expect_reg("R6", ev_addr(1, 1), 64'h0);
        expect_reg("R6", 'h05, 64'h2);
        chk("R8", 64'(irq), 64'h0);
        wr_reg('h03, 64'h2);
        chk("R8", 64'(irq), 64'h1);
        wr_reg('h06, 64'h2);
        expect_reg("R4", 'h05, 64'h0);
        chk("R8", 64'(irq), 64'h0);

        // R7 clear in the overflow cycle
        wr_reg(ev_addr(1, 1), 64'hFFFF_FFFF);
        @(negedge clk);
        evt[1] = 1'b1;
        wr = 1'b1; addr = AW'('h06); wdata = 64'h2;
        @(negedge clk);
        wr = 1'b0; evt = '0;
        expect_reg("R7", 'h05, 64'h2);
        chk("R8", 64'(irq), 64'h1);
        wr_reg('h06, 64'h2);

        // R6 R5 cycle counter wrap on bit 31
        wr_reg('h00, 64'h0);
        wr_reg('h01, 64'h8000_0000);
        wr_reg('h09, 64'hFFFF_FFFF_FFFF_FFFE);
        wr_reg('h00, 64'h1);
        @(negedge clk);
        @(negedge clk);
        expect_reg("R6", 'h09, 64'h0);
        expect_reg("R5", 'h05, 64'h8000_0000);
        wr_reg('h00, 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule